// File: doc/BRIEF.md
# Four-Mode Multiply-Accumulate Unit

This block computes products of two operands and either loads them into a 64-bit accumulator or adds them to it. It has four operations: a 16-by-16 multiply or multiply-accumulate, and a 32-by-32 multiply or multiply-accumulate. One control bit picks two's-complement or unsigned arithmetic for both operands. A single bank of 17-by-17 signed partial-product lanes serves all four operations. A wide product is built from four 16-bit partial products over one or more cycles. The number of cycles depends on the operation and on how many lanes are built.

A host pulses `start_i` while the unit is idle, with the operation, the signedness and both operands valid in the same cycle. The unit raises `busy_o` until the result is written. It then pulses `done_o` for one cycle. The two accumulator halves are read on separate ports, and a synchronous clear can zero the accumulator at any time.

Top module: `mmac_unit`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and both accumulator halves read zero.
- R2: `mode_i` has bit 1 select the wide (32x32) form and bit 0 select accumulation. Code 2'b00 multiplies `opa_i[15:0]` by `opb_i[15:0]` and overwrites the accumulator with the 32-bit product. The product is extended to 64 bits by sign when signed and by zeros when unsigned.
- R3: Code 2'b01 adds the extended 16x16 product to the previous accumulator value modulo 2^64.
- R4: Code 2'b10 overwrites the accumulator with the full 64-bit product of `opa_i` and `opb_i`.
- R5: Code 2'b11 adds the 64-bit product to the previous accumulator value modulo 2^64.
- R6: `signed_i` = 1 treats both operands as two's-complement; `signed_i` = 0 treats both as unsigned.
- R7: `start_i` is accepted on a clock edge where `busy_o` is low, and `busy_o` is high from the next cycle. With the default two lanes, the result and `done_o` appear exactly L edges after the accepting edge: L = 1 for 2'b00, 2 for 2'b01, 2 for 2'b10 and 3 for 2'b11.
- R8: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R9: A `start_i` that arrives while busy is ignored. Its operands and operation do not alter the running result, and it produces no extra `done_o`.
- R10: `acc_clr_i` zeroes the accumulator on the next edge. It wins over a result write on the same edge, although `done_o` still pulses.
- R11: `acc_hi_o` carries accumulator bits 63:32 and `acc_lo_o` carries bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| mode_i | input | 2 | Operation code: bit 1 wide, bit 0 accumulate |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opa_i | input | 32 | First operand (low 16 bits used in narrow modes) |
| opb_i | input | 32 | Second operand (low 16 bits used in narrow modes) |
| acc_clr_i | input | 1 | Synchronous accumulator clear |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result has been written |
| acc_hi_o | output | 32 | Accumulator bits 63:32 |
| acc_lo_o | output | 32 | Accumulator bits 31:0 |

## Verification
The accepting edge is counted as edge zero. Each result is due L edges later: L is 1 for the narrow multiply, 2 for the narrow accumulate and for the wide multiply, and 3 for the wide accumulate. The bench drives inputs and samples outputs on falling edges. After every rising edge up to L it checks that `done_o` is still low and `busy_o` high. At edge L it checks the pulse, the idle state and both accumulator halves, and at edge L+1 it checks that `done_o` has dropped. The clear-versus-write case raises the clear exactly for edge L. The ignored-start case drives a conflicting start on edge one and then watches several further cycles for a second pulse.

// File: rtl/mmac_pkg.sv
`timescale 1ns/1ps
package mmac_pkg;

   typedef enum logic [1:0] {
      OP_MUL16 = 2'b00,
      OP_MAC16 = 2'b01,
      OP_MUL32 = 2'b10,
      OP_MAC32 = 2'b11
   } mmac_op_e;

   // Cycles spent forming partial products for an operation.
   function automatic int prod_steps(input logic [1:0] op, input int lanes);
      return op[1] ? (4 / lanes) : 1;
   endfunction

   // Total busy cycles: product cycles plus one add cycle when accumulating.
   function automatic int total_steps(input logic [1:0] op, input int lanes);
      return prod_steps(op, lanes) + (op[0] ? 1 : 0);
   endfunction

endpackage

// File: rtl/mmac_lane.sv
`timescale 1ns/1ps
module mmac_lane #(
   parameter int LANES = 2,
   parameter int IDX   = 0,
   parameter int CW    = 3
) (
   input  logic [31:0]   a_q,
   input  logic [31:0]   b_q,
   input  logic          wide,
   input  logic          sgn,
   input  logic [CW-1:0] step,
   output logic [63:0]   pp
);
   localparam int KW = 6;

   logic [KW-1:0]      k;
   logic               ai, bi, valid;
   logic [15:0]        ah, bh;
   logic               a_top, b_top;
   logic signed [16:0] a17, b17;
   logic signed [33:0] prod;
   logic [63:0]        pext;

   // Partial-product index handled by this lane in this step.
   assign k     = KW'(step) * KW'(LANES) + KW'(IDX);
   assign ai    = k[0];
   assign bi    = k[1];
   assign valid = wide ? (k < KW'(4)) : (k == '0);

   assign ah    = ai ? a_q[31:16] : a_q[15:0];
   assign bh    = bi ? b_q[31:16] : b_q[15:0];
   // Only the most significant half of an operand carries its sign.
   assign a_top = wide ? ai : 1'b1;
   assign b_top = wide ? bi : 1'b1;
   assign a17   = {a_top & sgn & ah[15], ah};
   assign b17   = {b_top & sgn & bh[15], bh};

   assign prod  = a17 * b17;
   assign pext  = {{30{prod[33]}}, prod};

   always_comb begin
      if (!valid) begin
         pp = '0;
      end else begin
         unique case ({ai & bi, ai ^ bi})
            2'b00:   pp = pext;
            2'b01:   pp = pext << 16;
            default: pp = pext << 32;
         endcase
      end
   end
endmodule

// File: rtl/mmac_seq.sv
`timescale 1ns/1ps
module mmac_seq
   import mmac_pkg::*;
#(
   parameter int LANES = 2,
   parameter int CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    mode_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          accept_o,
   output logic [CW-1:0] step_o,
   output logic [1:0]    op_o,
   output logic          final_o,
   output logic          addph_o
);
   logic          busy_q, done_q;
   logic [CW-1:0] step_q;
   logic [1:0]    op_q;

   assign accept_o = start_i & ~busy_q;
   assign final_o  = (step_q == CW'(total_steps(op_q, LANES) - 1));
   assign addph_o  = op_q[0] & (step_q == CW'(prod_steps(op_q, LANES)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         step_q <= '0;
         op_q   <= OP_MUL16;
      end else begin
         done_q <= busy_q & final_o;
         if (accept_o) begin
            busy_q <= 1'b1;
            step_q <= '0;
            op_q   <= mode_i;
         end else if (busy_q) begin
            if (final_o) busy_q <= 1'b0;
            else         step_q <= step_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign step_o = step_q;
   assign op_o   = op_q;
endmodule

// File: rtl/mmac_accum.sv
`timescale 1ns/1ps
module mmac_accum #(
   parameter int AW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          accept_i,
   input  logic          step_en_i,
   input  logic          final_i,
   input  logic          addph_i,
   input  logic [AW-1:0] pp_sum_i,
   output logic [AW-1:0] acc_o
);
   logic [AW-1:0] sum_q, acc_q, sum_next;

   assign sum_next = sum_q + pp_sum_i + (addph_i ? acc_q : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         acc_q <= '0;
      end else begin
         if (accept_i)       sum_q <= '0;
         else if (step_en_i) sum_q <= sum_next;

         if (clear_i)                   acc_q <= '0;
         else if (step_en_i && final_i) acc_q <= sum_next;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/mmac_unit.sv
`timescale 1ns/1ps
module mmac_unit
   import mmac_pkg::*;
#(
   parameter int LANES = 2,
   parameter int DW    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    mode_i,
   input  logic          signed_i,
   input  logic [DW-1:0] opa_i,
   input  logic [DW-1:0] opb_i,
   input  logic          acc_clr_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] acc_hi_o,
   output logic [DW-1:0] acc_lo_o
);
   localparam int AW      = 2 * DW;
   localparam int MAX_LAT = (4 / LANES) + 1;
   localparam int CW      = $clog2(MAX_LAT + 1) + 1;

   // Elaboration-time parameter checks.
   if (DW != 32) begin : g_bad_dw
      $error("mmac_unit: DW must be 32");
   end
   if (LANES != 1 && LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("mmac_unit: LANES must be 1, 2 or 4");
   end

   logic          accept, final_s, addph, busy_s;
   logic [CW-1:0] step;
   logic [1:0]    op;
   logic [31:0]   a_q, b_q;
   logic          sgn_q;
   logic [AW-1:0] pp [LANES];
   logic [AW-1:0] pp_sum, acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         sgn_q <= 1'b0;
      end else if (accept) begin
         a_q   <= opa_i;
         b_q   <= opb_i;
         sgn_q <= signed_i;
      end
   end

   mmac_seq #(.LANES(LANES), .CW(CW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mode_i   (mode_i),
      .busy_o   (busy_s),
      .done_o   (done_o),
      .accept_o (accept),
      .step_o   (step),
      .op_o     (op),
      .final_o  (final_s),
      .addph_o  (addph)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      mmac_lane #(.LANES(LANES), .IDX(l), .CW(CW)) u_lane (
         .a_q  (a_q),
         .b_q  (b_q),
         .wide (op[1]),
         .sgn  (sgn_q),
         .step (step),
         .pp   (pp[l])
      );
   end

   always_comb begin
      pp_sum = '0;
      for (int l = 0; l < LANES; l++) pp_sum = pp_sum + pp[l];
   end

   mmac_accum #(.AW(AW)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (acc_clr_i),
      .accept_i  (accept),
      .step_en_i (busy_s),
      .final_i   (final_s),
      .addph_i   (addph),
      .pp_sum_i  (pp_sum),
      .acc_o     (acc)
   );

   assign busy_o   = busy_s;
   assign acc_hi_o = acc[AW-1:DW];
   assign acc_lo_o = acc[DW-1:0];
endmodule

// File: rtl/mmac_chk.sv
`timescale 1ns/1ps
module mmac_chk #(
   parameter int LANES = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic        acc_clr_i,
   input logic        busy_o,
   input logic        done_o,
   input logic [31:0] acc_hi_o,
   input logic [31:0] acc_lo_o
);
   localparam int MAX_LAT = (4 / LANES) + 1;

   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else        busy_run <= busy_o ? busy_run + 1 : 0;
   end

   // R7: no operation stays busy longer than the slowest mode
   always_ff @(posedge clk) begin
      if (rst_n) a_r7_busy_bound: assert (busy_run <= MAX_LAT);
   end

   a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr_i |=> ({acc_hi_o, acc_lo_o} == 64'd0));

   a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && !$past(acc_clr_i)) |-> $stable({acc_hi_o, acc_lo_o}));
endmodule

bind mmac_unit mmac_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .acc_clr_i (acc_clr_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .acc_hi_o  (acc_hi_o),
   .acc_lo_o  (acc_lo_o)
);

// File: tb/sim_mmac_unit.sv
`timescale 1ns/1ps
module sim_mmac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic        signed_i = 1'b0;
   logic [31:0] opa_i = '0;
   logic [31:0] opb_i = '0;
   logic        acc_clr_i = 1'b0;
   logic        busy_o, done_o;
   logic [31:0] acc_hi_o, acc_lo_o;

   int          errs = 0;
   int          total = 0;
   logic [63:0] model = '0;

   always #10 clk = ~clk;   // 50 MHz

   mmac_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mode_i    (mode_i),
      .signed_i  (signed_i),
      .opa_i     (opa_i),
      .opb_i     (opb_i),
      .acc_clr_i (acc_clr_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .acc_hi_o  (acc_hi_o),
      .acc_lo_o  (acc_lo_o)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_prod(input logic [1:0] md, input logic s,
                                            input logic [31:0] a, input logic [31:0] b);
      logic [63:0] ea, eb;
      if (md[1]) begin
         ea = s ? {{32{a[31]}}, a} : {32'd0, a};
         eb = s ? {{32{b[31]}}, b} : {32'd0, b};
      end else begin
         ea = s ? {{48{a[15]}}, a[15:0]} : {48'd0, a[15:0]};
         eb = s ? {{48{b[15]}}, b[15:0]} : {48'd0, b[15:0]};
      end
      return ea * eb;
   endfunction

   function automatic int lat_of(input logic [1:0] md);
      case (md)
         2'b00:   return 1;
         2'b01:   return 2;
         2'b10:   return 2;
         default: return 3;
      endcase
   endfunction

   // One operation with R7/R8 timing checks; optional ignored start and clear at write.
   task automatic run_op(input logic [1:0] md, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input string req,
                         input bit ign_start, input bit clr_at_wr);
      int          lat = lat_of(md);
      logic [63:0] exp;
      exp = md[0] ? model + ref_prod(md, s, a, b) : ref_prod(md, s, a, b);
      if (clr_at_wr) exp = '0;
      @(negedge clk);
      start_i = 1'b1; mode_i = md; signed_i = s; opa_i = a; opb_i = b;
      @(negedge clk);
      start_i = 1'b0;
      opa_i = 32'hDEAD_BEEF; opb_i = 32'h1234_5678;
      chk(busy_o === 1'b1, "R7 busy after accept", {63'd0, busy_o}, 64'd1);
      for (int n = 1; n <= lat; n++) begin
         if (ign_start && n == 1) begin
            start_i = 1'b1; mode_i = ~md; signed_i = ~s;
         end
         if (ign_start && n == 2) start_i = 1'b0;
         if (clr_at_wr && n == lat) acc_clr_i = 1'b1;
         @(negedge clk);
         acc_clr_i = 1'b0;
         if (n < lat) begin
            chk(done_o === 1'b0 && busy_o === 1'b1, "R7 still busy before latency",
                {62'd0, done_o, busy_o}, 64'd1);
         end else begin
            chk(done_o === 1'b1 && busy_o === 1'b0, "R7/R8 done at latency, idle",
                {62'd0, done_o, busy_o}, 64'd2);
            chk({acc_hi_o, acc_lo_o} === exp, req, {acc_hi_o, acc_lo_o}, exp);
         end
      end
      start_i = 1'b0;
      @(negedge clk);
      chk(done_o === 1'b0, "R8 done lasts one cycle", {63'd0, done_o}, 64'd0);
      if (ign_start) begin
         for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk(done_o === 1'b0 && busy_o === 1'b0, "R9 no extra done from ignored start",
                {62'd0, done_o, busy_o}, 64'd0);
         end
         chk({acc_hi_o, acc_lo_o} === exp, "R9 result unaltered", {acc_hi_o, acc_lo_o}, exp);
      end
      model = exp;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset",
          {62'd0, busy_o, done_o}, 64'd0);
      chk({acc_hi_o, acc_lo_o} === 64'd0, "R1 accumulator zero", {acc_hi_o, acc_lo_o}, 64'd0);
   endtask

   task automatic t_mul16();
      run_op(2'b00, 1'b1, 32'hFFFF_8000, 32'h0000_0003, "R2 R6 signed narrow multiply", 0, 0);
      run_op(2'b00, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, "R2 R6 unsigned narrow multiply", 0, 0);
      run_op(2'b00, 1'b1, 32'h1234_8000, 32'h5678_8000, "R2 signed min squared", 0, 0);
   endtask

   task automatic t_mac16();
      run_op(2'b01, 1'b1, 32'h0000_FFFF, 32'h0000_0005, "R3 signed narrow accumulate", 0, 0);
      run_op(2'b01, 1'b0, 32'h0000_FFFF, 32'h0000_0002, "R3 unsigned narrow accumulate", 0, 0);
   endtask

   task automatic t_mul32();
      run_op(2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 R6 unsigned wide multiply", 0, 0);
      run_op(2'b10, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 R6 signed wide multiply", 0, 0);
      run_op(2'b10, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R4 signed extremes", 0, 0);
   endtask

   task automatic t_mac32();
      run_op(2'b11, 1'b1, 32'h8000_0000, 32'h8000_0000, "R5 signed wide accumulate", 0, 0);
      run_op(2'b11, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 unsigned wrap accumulate", 0, 0);
   endtask

   task automatic t_busy_start();
      run_op(2'b11, 1'b0, 32'h0001_0003, 32'h0002_0007, "R9 accumulate under ignored start", 1, 0);
   endtask

   task automatic t_halves();
      run_op(2'b10, 1'b0, 32'h0001_0000, 32'h0002_0001, "R11 wide load", 0, 0);
      chk(acc_hi_o === 32'h0000_0002, "R11 high half", {32'd0, acc_hi_o}, 64'h2);
      chk(acc_lo_o === 32'h0001_0000, "R11 low half", {32'd0, acc_lo_o}, 64'h1_0000);
   endtask

   task automatic t_clear();
      @(negedge clk);
      acc_clr_i = 1'b1;
      @(negedge clk);
      acc_clr_i = 1'b0;
      chk({acc_hi_o, acc_lo_o} === 64'd0, "R10 clear while idle", {acc_hi_o, acc_lo_o}, 64'd0);
      model = '0;
      run_op(2'b01, 1'b1, 32'h0000_0100, 32'h0000_0100, "R10 load after clear", 0, 0);
      run_op(2'b01, 1'b1, 32'h0000_0123, 32'h0000_0456, "R10 clear wins over write", 0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mul16();
      t_mac16();
      t_mul32();
      t_mac32();
      t_busy_start();
      t_halves();
      t_clear();
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end

   initial begin
      #2_000_000;
      total++;
      errs++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end
endmodule